// File: doc/BRIEF.md
# Multithreaded Issue Thread Selector

This block decides, every clock cycle, which of `T` hardware threads may issue into a shared pipeline. Each thread owns a program counter held inside the block, so moving from one thread to another needs no save or restore of state. Per thread, the pipeline reports a stall bit and a flag that marks the stall as long (for example a miss to the second cache level) rather than short (for example a data hazard). The block returns the chosen thread number, that thread's program counter and an issue-valid strobe. The chosen program counter steps forward by a fixed amount on each valid issue.

Two policies share one interface and are picked with the `mode` input. In interleaved mode (`mode`=0) the choice rotates every cycle over the threads that are not stalled. In switch-on-miss mode (`mode`=1) one thread keeps the pipeline until it reports a long stall. A short stall in that mode just idles the pipeline. A load port lets the surrounding logic redirect any thread to a new program counter.

Top module: `mt_thread_sel`

## Requirements
- R1: After reset, thread i holds program counter i*PC_STRIDE (0x100 by default) and the thread pointer is T-1. With all threads stalled, the outputs show issue_valid=0, issue_tid=T-1 and that thread's program counter.
- R2: In interleaved mode (mode=0), the search for the issuing thread starts at the thread numbered one above the last thread that issued, wrapping from T-1 to 0. With all threads ready, issue_tid therefore steps by one every cycle.
- R3: In interleaved mode, a thread with its stall bit set is skipped whatever its long flag says, and the next ready thread in rotation order issues in the same cycle.
- R4: When no thread is eligible, issue_valid is 0, issue_tid shows the held pointer, and the pointer does not move.
- R5: In switch-on-miss mode (mode=1), the current thread issues on every cycle in which it is not stalled, and issue_tid does not change.
- R6: In switch-on-miss mode, a short stall (stall=1, long=0) of the current thread gives issue_valid=0 and no switch. The same thread issues once its stall clears.
- R7: In switch-on-miss mode, a long stall (stall=1, long=1) of the current thread gives issue_valid=0 for that cycle, which is the one bubble. In the next cycle the pointer has moved to the first ready thread above the current one in rotation order.
- R8: In switch-on-miss mode, a long stall with no other thread ready leaves the pointer on the current thread.
- R9: A valid issue adds PC_INC (4) to the issuing thread's program counter. No other thread's counter changes.
- R10: pc_load_en writes pc_load_val into thread pc_load_tid at the clock edge. This write wins over an increment to the same thread in that cycle.
- R11: issue_pc always equals the current program counter of the thread shown on issue_tid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 0 = interleave every cycle, 1 = switch only on a long stall |
| stall | input | T | Per-thread stall bit |
| stall_long | input | T | Per-thread long-stall flag, meaningful when the stall bit is set |
| pc_load_en | input | 1 | Program counter load strobe |
| pc_load_tid | input | log2(T) | Thread written by a load |
| pc_load_val | input | PC_W | Value written by a load |
| issue_valid | output | 1 | The shown thread issues this cycle |
| issue_tid | output | log2(T) | Selected thread, or the held pointer when idle |
| issue_pc | output | PC_W | Program counter of issue_tid |

## Verification
The bench targets the wrap of the rotation. A design that restarts the search at thread 0 instead of one above the last issuer would repeat the low threads and starve the high ones. It stalls every thread at once, where a selector that moved its pointer anyway would resume on the wrong thread. In switch-on-miss mode it checks a short stall, which must not switch, and a long stall with and without another thread ready. A missing bubble, or a switch onto a stalled thread, shows up as a wrong tid or a spurious issue. It also loads a counter in the same cycle that the thread issues: a design that let the increment win would resume four bytes past the loaded address.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

  typedef enum logic {
    SEL_INTERLEAVE = 1'b0,
    SEL_ON_MISS    = 1'b1
  } sel_mode_e;

  // Rotation neighbour of a thread index among n threads.
  function automatic int rot_next(input int idx, input int step, input int n);
    return (idx + step) % n;
  endfunction

  // Reset program counter of a thread.
  function automatic longint reset_pc(input int idx, input longint stride);
    return longint'(idx) * stride;
  endfunction

endpackage

// File: rtl/mt_rr_pick.sv
module mt_rr_pick #(
  parameter int T   = 4,
  parameter int IDW = 2
) (
  input  logic [IDW-1:0] base,
  input  logic [T-1:0]   req,
  output logic           found,
  output logic [IDW-1:0] pick
);
  import mt_sched_pkg::*;

  // Nearest requester strictly above base in rotation order; base itself last.
  always_comb begin
    found = 1'b0;
    pick  = base;
    for (int k = T; k >= 1; k--) begin
      int idx;
      idx = rot_next(int'(base), k, T);
      if (req[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end

endmodule

// File: rtl/mt_pc_bank.sv
module mt_pc_bank #(
  parameter int T         = 4,
  parameter int IDW       = 2,
  parameter int PC_W      = 32,
  parameter int PC_INC    = 4,
  parameter int PC_STRIDE = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en,
  input  logic [IDW-1:0]    inc_tid,
  input  logic              ld_en,
  input  logic [IDW-1:0]    ld_tid,
  input  logic [PC_W-1:0]   ld_val,
  output logic [T*PC_W-1:0] pc_flat
);
  import mt_sched_pkg::*;

  for (genvar g = 0; g < T; g++) begin : g_thread
    logic [PC_W-1:0] pc_q;
    logic            ld_hit;
    logic            inc_hit;
    assign ld_hit  = ld_en  && (ld_tid  == IDW'(g));
    assign inc_hit = inc_en && (inc_tid == IDW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pc_q <= PC_W'(reset_pc(g, longint'(PC_STRIDE)));
      else if (ld_hit)  pc_q <= ld_val;
      else if (inc_hit) pc_q <= pc_q + PC_W'(PC_INC);
    end

    assign pc_flat[g*PC_W +: PC_W] = pc_q;
  end

endmodule

// File: rtl/mt_thread_sel.sv
module mt_thread_sel #(
  parameter int T         = 4,
  parameter int PC_W      = 32,
  parameter int PC_INC    = 4,
  parameter int PC_STRIDE = 256,
  localparam int IDW      = (T > 1) ? $clog2(T) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic [T-1:0]    stall,
  input  logic [T-1:0]    stall_long,
  input  logic            pc_load_en,
  input  logic [IDW-1:0]  pc_load_tid,
  input  logic [PC_W-1:0] pc_load_val,
  output logic            issue_valid,
  output logic [IDW-1:0]  issue_tid,
  output logic [PC_W-1:0] issue_pc
);
  import mt_sched_pkg::*;

  logic [IDW-1:0]    ptr_q, ptr_d;
  logic [T-1:0]      ready, cur_mask, arb_req;
  logic              on_miss;
  logic              cur_ready, cur_long;
  logic              arb_found;
  logic [IDW-1:0]    arb_pick;
  logic              switch_evt;   // switch-on-miss hand-over, bubble cycle
  logic              idle_evt;     // nothing issues this cycle
  logic [T*PC_W-1:0] pc_flat;

  assign on_miss   = (sel_mode_e'(mode) == SEL_ON_MISS);
  assign ready     = ~stall;
  assign cur_mask  = T'(1) << ptr_q;
  assign cur_ready = ready[ptr_q];
  assign cur_long  = stall[ptr_q] & stall_long[ptr_q];
  assign arb_req   = on_miss ? (ready & ~cur_mask) : ready;

  mt_rr_pick #(.T(T), .IDW(IDW)) u_pick (
    .base  (ptr_q),
    .req   (arb_req),
    .found (arb_found),
    .pick  (arb_pick)
  );

  always_comb begin
    if (on_miss) begin
      issue_valid = cur_ready;
      issue_tid   = ptr_q;
    end else begin
      issue_valid = arb_found;
      issue_tid   = arb_found ? arb_pick : ptr_q;
    end
  end

  assign switch_evt = on_miss && cur_long && arb_found;
  assign idle_evt   = !issue_valid;

  always_comb begin
    ptr_d = ptr_q;
    if (!on_miss && arb_found) ptr_d = arb_pick;
    else if (switch_evt)       ptr_d = arb_pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= IDW'(T - 1);
    else        ptr_q <= ptr_d;
  end

  mt_pc_bank #(
    .T(T), .IDW(IDW), .PC_W(PC_W), .PC_INC(PC_INC), .PC_STRIDE(PC_STRIDE)
  ) u_pcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (issue_valid),
    .inc_tid (issue_tid),
    .ld_en   (pc_load_en),
    .ld_tid  (pc_load_tid),
    .ld_val  (pc_load_val),
    .pc_flat (pc_flat)
  );

  assign issue_pc = pc_flat[issue_tid*PC_W +: PC_W];

endmodule

// File: rtl/mt_thread_sel_chk.sv
module mt_thread_sel_chk #(
  parameter int T      = 4,
  parameter int PC_W   = 32,
  parameter int PC_INC = 4,
  parameter int IDW    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode,
  input logic [T-1:0]      stall,
  input logic [T-1:0]      stall_long,
  input logic              pc_load_en,
  input logic [IDW-1:0]    pc_load_tid,
  input logic [PC_W-1:0]   pc_load_val,
  input logic              issue_valid,
  input logic [IDW-1:0]    issue_tid,
  input logic [PC_W-1:0]   issue_pc,
  input logic [T*PC_W-1:0] pc_flat
);

  function automatic logic [IDW-1:0] tid_after(input logic [IDW-1:0] t);
    return (int'(t) == T - 1) ? '0 : t + 1'b1;
  endfunction

  logic [T-1:0] others_ready;
  assign others_ready = ~stall & ~(T'(1) << issue_tid);

  p_no_stalled_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !stall[issue_tid]);

  p_all_stalled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (&stall) |-> !issue_valid);

  p_fine_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && issue_valid) |=> (mode || (stall != '0) || issue_tid == tid_after($past(issue_tid))));

  p_coarse_stay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && issue_valid) |=> (!(mode && issue_valid) || issue_tid == $past(issue_tid)));

  p_long_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && stall[issue_tid] && stall_long[issue_tid] && others_ready != '0)
      |=> issue_tid != $past(issue_tid));

  p_pc_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !(pc_load_en && pc_load_tid == issue_tid))
      |=> pc_flat[$past(issue_tid)*PC_W +: PC_W] == $past(issue_pc) + PC_W'(PC_INC));

  p_pc_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_en |=> pc_flat[$past(pc_load_tid)*PC_W +: PC_W] == $past(pc_load_val));

  p_pc_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    issue_pc == pc_flat[issue_tid*PC_W +: PC_W]);

endmodule

bind mt_thread_sel mt_thread_sel_chk #(
  .T(T), .PC_W(PC_W), .PC_INC(PC_INC), .IDW(IDW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode),
  .stall       (stall),
  .stall_long  (stall_long),
  .pc_load_en  (pc_load_en),
  .pc_load_tid (pc_load_tid),
  .pc_load_val (pc_load_val),
  .issue_valid (issue_valid),
  .issue_tid   (issue_tid),
  .issue_pc    (issue_pc),
  .pc_flat     (pc_flat)
);

// File: tb/mt_thread_sel_bench.sv
module mt_thread_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode = 1'b0;
  logic [3:0]  stall = 4'b1111;
  logic [3:0]  stall_long = 4'b0000;
  logic        pc_load_en = 1'b0;
  logic [1:0]  pc_load_tid = 2'd0;
  logic [31:0] pc_load_val = 32'd0;
  logic        issue_valid;
  logic [1:0]  issue_tid;
  logic [31:0] issue_pc;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mt_thread_sel u_mt_thread_sel (
    .clk(clk), .rst_n(rst_n), .mode(mode), .stall(stall), .stall_long(stall_long),
    .pc_load_en(pc_load_en), .pc_load_tid(pc_load_tid), .pc_load_val(pc_load_val),
    .issue_valid(issue_valid), .issue_tid(issue_tid), .issue_pc(issue_pc)
  );

  // {req, mode, stall[3:0], long[3:0], exp_valid, exp_tid, exp_pc}
  localparam logic [47:0] VEC [NV] = '{
    {4'd2,  1'b0, 4'b0000, 4'b0000, 1'b1, 2'd0, 32'h0000}, // R2 first after reset
    {4'd2,  1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 32'h0100}, // R2
    {4'd3,  1'b0, 4'b0100, 4'b0000, 1'b1, 2'd3, 32'h0300}, // R3 skip 2
    {4'd3,  1'b0, 4'b0001, 4'b0000, 1'b1, 2'd1, 32'h0104}, // R3 wrap, skip 0
    {4'd4,  1'b0, 4'b1111, 4'b0000, 1'b0, 2'd1, 32'h0108}, // R4 idle
    {4'd4,  1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 32'h0200}, // R4 held pointer
    {4'd5,  1'b1, 4'b0000, 4'b0000, 1'b1, 2'd2, 32'h0204}, // R5
    {4'd5,  1'b1, 4'b0000, 4'b0000, 1'b1, 2'd2, 32'h0208}, // R5
    {4'd6,  1'b1, 4'b0100, 4'b0000, 1'b0, 2'd2, 32'h020c}, // R6 short stall
    {4'd6,  1'b1, 4'b0000, 4'b0000, 1'b1, 2'd2, 32'h020c}, // R6 resume
    {4'd7,  1'b1, 4'b0100, 4'b0100, 1'b0, 2'd2, 32'h0210}, // R7 bubble
    {4'd7,  1'b1, 4'b0000, 4'b0000, 1'b1, 2'd3, 32'h0304}, // R7 new thread
    {4'd8,  1'b1, 4'b1111, 4'b1000, 1'b0, 2'd3, 32'h0308}, // R8 no one ready
    {4'd8,  1'b1, 4'b0000, 4'b0000, 1'b1, 2'd3, 32'h0308}, // R8 stayed
    {4'd7,  1'b1, 4'b1010, 4'b1000, 1'b0, 2'd3, 32'h030c}, // R7 skip stalled 1
    {4'd7,  1'b1, 4'b0000, 4'b0000, 1'b1, 2'd0, 32'h0004}, // R7 lands on 0
    {4'd9,  1'b0, 4'b0000, 4'b0000, 1'b1, 2'd1, 32'h0108}, // R9 back to rotation
    {4'd11, 1'b0, 4'b0000, 4'b0000, 1'b1, 2'd2, 32'h0210}  // R11
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out(input string tag, input logic v, input logic [1:0] t,
                           input logic [31:0] p);
    check(tag, "issue_valid", 32'(issue_valid), 32'(v));
    check(tag, "issue_tid",   32'(issue_tid),   32'(t));
    check(tag, "issue_pc",    issue_pc,         p);
  endtask

  task automatic drive(input logic m, input logic [3:0] s, input logic [3:0] l);
    mode = m; stall = s; stall_long = l;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state with everything stalled
    drive(1'b0, 4'b1111, 4'b0000);
    #1 check_out("R1", 1'b0, 2'd3, 32'h0300);

    for (int i = 0; i < NV; i++) begin
      logic [47:0] v;
      v = VEC[i];
      drive(v[43], v[42:39], v[38:35]);
      #1 check_out($sformatf("R%0d", v[47:44]), v[34], v[33:32], v[31:0]);
      @(negedge clk);
    end

    // R10: load thread 1 while thread 2 issues
    drive(1'b0, 4'b1011, 4'b0000);
    pc_load_en = 1'b1; pc_load_tid = 2'd1; pc_load_val = 32'h8000;
    #1 check_out("R9", 1'b1, 2'd2, 32'h0214);
    @(negedge clk);
    pc_load_en = 1'b0;
    drive(1'b0, 4'b1101, 4'b0000);
    #1 check_out("R10", 1'b1, 2'd1, 32'h8000);
    @(negedge clk);
    // R10: load and issue of the same thread in one cycle, load wins
    pc_load_en = 1'b1; pc_load_val = 32'h9000;
    #1 check_out("R10", 1'b1, 2'd1, 32'h8004);
    @(negedge clk);
    pc_load_en = 1'b0;
    #1 check_out("R10", 1'b1, 2'd1, 32'h9000);
    @(negedge clk);
    // R9: thread 0 untouched by the others' increments and loads
    drive(1'b0, 4'b1110, 4'b0000);
    #1 check_out("R9", 1'b1, 2'd0, 32'h0008);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule